// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings a panel timing controller up and down in a safe order. On an init request it emits a fixed series of 8-bit register words on a valid/ready stream, pausing a set number of millisecond ticks at three points. Midway through, it hands a common-voltage level to a separate DAC-write block through a request/done handshake. It then writes a phase-adjust word and a resolution word, both chosen from the requested line count. A suspend request runs a separate shutdown series that starts with a long settling pause, and it leaves the panel marked as off.

When the panel is already on, an init request takes a short path that only rewrites the phase and resolution words. A request that arrives while a series is running is kept pending and served once the current series has finished. Millisecond timing comes from an external one-cycle `ms_tick` strobe, so the block has no clock-frequency dependence.

Top module: `lcd_pwr_seq`

## Requirements
- R1: Every stream word is {address[2:0], data[4:0]} in bits [7:5] and [4:0]. While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` is unchanged.
- R2: A full power-up, taken when `panel_on` is 0, emits these words in this order: DF, 63, 80, 84, 67, C9, then the common-voltage handoff, then 77, 86, C1, 7F, 87, C0, the phase word, E0, and the resolution word (hex). Afterwards `panel_on` is 1.
- R3: The block waits 3 `ms_tick` pulses after word 84 and 2 after word 86 in power-up, 1 after word E0, and 34 at the start of suspend. During a wait it shows no stream or handoff activity. The next item appears in the cycle after the last counted tick.
- R4: In the handoff, `comv_req` stays high with stable `comv_level` and `comv_base` until `comv_done`, and no stream word is offered meanwhile. In power-up the level is `comv_set` when `comv_valid` is 1 and 125 otherwise, with base 04.
- R5: The phase word has address 1. For line counts 480 and 640 its data is {phase_set, 1} when `phase_valid` is 1 and 1 otherwise. For any other line count it is 19 (9 shifted left, plus 1). The phase settings are sampled when the series starts.
- R6: The resolution word has address 0. Its data is 0 for 480 or 640 lines and 1 otherwise. It is the last word of every init series.
- R7: An init request while `panel_on` is 1 emits only the phase word and then the resolution word, and `panel_on` stays 1.
- R8: Suspend waits, then emits 86, C8, 74, a handoff with level 0 and base 14, then 84, 64, DE, 60, 80. It then clears `panel_on`.
- R9: Requests that arrive while `busy` is high are held. If both kinds are pending, suspend is served first. Among several pending init requests, the line count of the last one is used.
- R10: After reset `busy`, `wr_valid`, `comv_req` and `panel_on` are 0. `busy` is high for the whole of each series. While `busy` is low, no word or handoff is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | One-cycle init request |
| init_lines | input | MODE_W (11) | Line count that goes with init_req |
| suspend_req | input | 1 | One-cycle suspend request |
| phase_valid | input | 1 | A phase setting is configured |
| phase_set | input | PH_W (4) | Phase setting |
| comv_valid | input | 1 | A common-voltage value is configured |
| comv_set | input | CV_W (8) | Common-voltage value |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| wr_valid | output | 1 | Register word valid |
| wr_ready | input | 1 | Register word accepted |
| wr_data | output | 8 | Register word |
| comv_req | output | 1 | Common-voltage write request to the DAC block |
| comv_done | input | 1 | DAC block finished the write |
| comv_level | output | CV_W (8) | Common-voltage level to write |
| comv_base | output | 5 | Power0 data bits held during the DAC write |
| busy | output | 1 | A series is running |
| panel_on | output | 1 | Panel counts as initialised |

## Verification
A corrupted step index or series select shows at the ports as a wrong word, or a word in the wrong place. This appears at the very next accepted word, and any skipped or repeated item breaks the expected order at once. A delay counter that is off by one moves the first word after a pause by a whole tick interval. A stale `panel_on` picks the wrong path, full versus short, and the mismatch shows on the first word of the following init. The bench compares every cycle against a queue-based model that knows which items may appear, so an early, late or extra word is caught in the cycle where it shows up.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

   typedef enum logic [1:0] {K_WR, K_CV, K_DLY, K_END} kind_e;
   typedef enum logic [1:0] {S_UP, S_FAST, S_DOWN} seq_e;
   typedef enum logic [1:0] {D_VDD, D_GATE, D_SETTLE, D_SUSP} dly_e;

   typedef struct packed {
      kind_e      kind;
      logic [7:0] word;
      dly_e       dly;
      logic [4:0] cv_base;
   } step_t;

   // register addresses decoded by the timing controller
   localparam logic [2:0] A_RES   = 3'd0;
   localparam logic [2:0] A_PHASE = 3'd1;
   localparam logic [2:0] A_PWR0  = 3'd3;
   localparam logic [2:0] A_PWR1  = 3'd4;
   localparam logic [2:0] A_PORT  = 3'd6;
   localparam logic [2:0] A_POL   = 3'd7;

   // power0 data bits
   localparam logic [4:0] P0_CLK  = 5'h01;
   localparam logic [4:0] P0_DOUT = 5'h02;
   localparam logic [4:0] P0_DAC  = 5'h04;
   localparam logic [4:0] P0_COM  = 5'h08;
   localparam logic [4:0] P0_VCC5 = 5'h10;
   // power1 data bits
   localparam logic [4:0] P1_VW   = 5'h01;
   localparam logic [4:0] P1_GNEG = 5'h02;
   localparam logic [4:0] P1_VDD  = 5'h04;
   // port-control data bits
   localparam logic [4:0] PC_INIT   = 5'h01;
   localparam logic [4:0] PC_INIOFF = 5'h02;
   localparam logic [4:0] PC_PDWN   = 5'h04;
   localparam logic [4:0] PC_COMOFF = 5'h08;
   localparam logic [4:0] PC_DACOFF = 5'h10;

   function automatic step_t st_wr(input logic [2:0] a, input logic [4:0] d);
      st_wr = '{kind: K_WR, word: {a, d}, dly: D_VDD, cv_base: 5'd0};
   endfunction

   function automatic step_t st_dly(input dly_e s);
      st_dly = '{kind: K_DLY, word: 8'd0, dly: s, cv_base: 5'd0};
   endfunction

   function automatic step_t st_cv(input logic [4:0] base);
      st_cv = '{kind: K_CV, word: 8'd0, dly: D_VDD, cv_base: base};
   endfunction

   function automatic step_t st_end();
      st_end = '{kind: K_END, word: 8'd0, dly: D_VDD, cv_base: 5'd0};
   endfunction

endpackage

// File: rtl/lcdseq_req.sv
module lcdseq_req #(
   parameter int MODE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_req,
   input  logic [MODE_W-1:0] init_lines,
   input  logic              suspend_req,
   input  logic              take_init,
   input  logic              take_susp,
   output logic              init_pend,
   output logic              susp_pend,
   output logic [MODE_W-1:0] pend_lines
);

   initial assert (MODE_W >= 10) else $error("MODE_W too small for 640 lines");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_pend  <= 1'b0;
         susp_pend  <= 1'b0;
         pend_lines <= '0;
      end else begin
         if (init_req) begin
            init_pend  <= 1'b1;
            pend_lines <= init_lines;
         end else if (take_init) begin
            init_pend  <= 1'b0;
         end
         if (suspend_req)    susp_pend <= 1'b1;
         else if (take_susp) susp_pend <= 1'b0;
      end
   end

   // a request is never lost, even when it meets a take in the same cycle
   assert_init_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_req |=> init_pend);
   assert_susp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_req |=> susp_pend);

endmodule

// File: rtl/lcdseq_table.sv
module lcdseq_table
   import lcdseq_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  seq_e             seq,
   input  logic [IDX_W-1:0] idx,
   input  logic [4:0]       phase_dat,
   input  logic [4:0]       res_dat,
   output step_t            step
);

   initial assert (IDX_W >= 5) else $error("IDX_W cannot index the power-up series");

   always_comb begin
      step = st_end();
      unique case (seq)
         S_UP: begin
            case (idx)
               IDX_W'(0):  step = st_wr(A_PORT, PC_INIT | PC_INIOFF | PC_PDWN | PC_COMOFF | PC_DACOFF);
               IDX_W'(1):  step = st_wr(A_PWR0, P0_CLK | P0_DOUT);
               IDX_W'(2):  step = st_wr(A_PWR1, 5'h00);
               IDX_W'(3):  step = st_wr(A_PWR1, P1_VDD);
               IDX_W'(4):  step = st_dly(D_VDD);
               IDX_W'(5):  step = st_wr(A_PWR0, P0_CLK | P0_DOUT | P0_DAC);
               IDX_W'(6):  step = st_wr(A_PORT, PC_INIT | PC_COMOFF);
               IDX_W'(7):  step = st_cv(P0_DAC);
               IDX_W'(8):  step = st_wr(A_PWR0, P0_CLK | P0_DOUT | P0_DAC | P0_VCC5);
               IDX_W'(9):  step = st_wr(A_PWR1, P1_GNEG | P1_VDD);
               IDX_W'(10): step = st_dly(D_GATE);
               IDX_W'(11): step = st_wr(A_PORT, PC_INIT);
               IDX_W'(12): step = st_wr(A_PWR0, P0_CLK | P0_DOUT | P0_DAC | P0_COM | P0_VCC5);
               IDX_W'(13): step = st_wr(A_PWR1, P1_VW | P1_GNEG | P1_VDD);
               IDX_W'(14): step = st_wr(A_PORT, 5'h00);
               IDX_W'(15): step = st_wr(A_PHASE, phase_dat);
               IDX_W'(16): step = st_wr(A_POL, 5'h00);
               IDX_W'(17): step = st_dly(D_SETTLE);
               IDX_W'(18): step = st_wr(A_RES, res_dat);
               default:    step = st_end();
            endcase
         end
         S_FAST: begin
            case (idx)
               IDX_W'(0): step = st_wr(A_PHASE, phase_dat);
               IDX_W'(1): step = st_wr(A_RES, res_dat);
               default:   step = st_end();
            endcase
         end
         default: begin
            case (idx)
               IDX_W'(0): step = st_dly(D_SUSP);
               IDX_W'(1): step = st_wr(A_PWR1, P1_GNEG | P1_VDD);
               IDX_W'(2): step = st_wr(A_PORT, PC_COMOFF);
               IDX_W'(3): step = st_wr(A_PWR0, P0_DAC | P0_VCC5);
               IDX_W'(4): step = st_cv(P0_DAC | P0_VCC5);
               IDX_W'(5): step = st_wr(A_PWR1, P1_VDD);
               IDX_W'(6): step = st_wr(A_PWR0, P0_VCC5 & 5'h00 | P0_DAC);
               IDX_W'(7): step = st_wr(A_PORT, PC_INIOFF | PC_DACOFF | PC_PDWN | PC_COMOFF);
               IDX_W'(8): step = st_wr(A_PWR0, 5'h00);
               IDX_W'(9): step = st_wr(A_PWR1, 5'h00);
               default:   step = st_end();
            endcase
         end
      endcase
   end

endmodule

// File: rtl/lcdseq_msdelay.sv
module lcdseq_msdelay
   import lcdseq_pkg::*;
#(
   parameter int VDD_MS    = 3,
   parameter int GATE_MS   = 2,
   parameter int SETTLE_MS = 1,
   parameter int SUSP_MS   = 34
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  dly_e sel,
   input  logic ms_tick,
   output logic done
);

   localparam int MAX_A  = (VDD_MS > GATE_MS) ? VDD_MS : GATE_MS;
   localparam int MAX_B  = (SETTLE_MS > SUSP_MS) ? SETTLE_MS : SUSP_MS;
   localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W  = $clog2(MAX_MS + 1);

   initial assert (VDD_MS > 0 && GATE_MS > 0 && SETTLE_MS > 0 && SUSP_MS > 0)
      else $error("every wait must be at least one tick");

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target;

   always_comb begin
      unique case (sel)
         D_VDD:    target = CNT_W'(VDD_MS);
         D_GATE:   target = CNT_W'(GATE_MS);
         D_SETTLE: target = CNT_W'(SETTLE_MS);
         default:  target = CNT_W'(SUSP_MS);
      endcase
   end

   assign done = active && ms_tick && (cnt == target - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (!active || done)  cnt <= '0;
      else if (ms_tick)          cnt <= cnt + CNT_W'(1);
   end

   // the tick count of a wait never runs past its target
   assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> cnt < target);
   // a wait ends only on a tick
   assert_wait_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active && !ms_tick |=> cnt == $past(cnt) || !$past(active));

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
   import lcdseq_pkg::*;
#(
   parameter int MODE_W      = 11,
   parameter int PH_W        = 4,
   parameter int CV_W        = 8,
   parameter int IDX_W       = 5,
   parameter int N_VGA       = 2,
   parameter logic [N_VGA*MODE_W-1:0] VGA_LINES = {MODE_W'(640), MODE_W'(480)},
   parameter int PHASE_QVGA  = 9,
   parameter int COMV_DEFAULT = 125,
   parameter int VDD_MS      = 3,
   parameter int GATE_MS     = 2,
   parameter int SETTLE_MS   = 1,
   parameter int SUSP_MS     = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_req,
   input  logic [MODE_W-1:0] init_lines,
   input  logic              suspend_req,
   input  logic              phase_valid,
   input  logic [PH_W-1:0]   phase_set,
   input  logic              comv_valid,
   input  logic [CV_W-1:0]   comv_set,
   input  logic              ms_tick,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [7:0]        wr_data,
   output logic              comv_req,
   input  logic              comv_done,
   output logic [CV_W-1:0]   comv_level,
   output logic [4:0]        comv_base,
   output logic              busy,
   output logic              panel_on
);

   initial assert (PH_W == 4) else $error("phase field holds exactly four bits");
   initial assert (PHASE_QVGA >= 0 && PHASE_QVGA < 16) else $error("PHASE_QVGA out of range");
   initial assert (COMV_DEFAULT < (1 << CV_W)) else $error("COMV_DEFAULT too wide");
   initial assert (N_VGA >= 1) else $error("need at least one full-resolution line count");

   typedef enum logic {ST_IDLE, ST_RUN} state_e;

   state_e           state;
   seq_e             seq;
   logic [IDX_W-1:0] idx;
   logic [4:0]       phase_dat;
   logic [4:0]       res_dat;
   logic [CV_W-1:0]  cv_level;
   step_t            step;
   logic             dly_done;
   logic             init_pend, susp_pend;
   logic [MODE_W-1:0] pend_lines;
   logic             take_init, take_susp;
   logic [N_VGA-1:0] vga_hit;
   logic             is_vga;

   // full-resolution line counts, one comparator per entry
   for (genvar g = 0; g < N_VGA; g++) begin : g_vga
      assign vga_hit[g] = (pend_lines == VGA_LINES[g*MODE_W +: MODE_W]);
   end
   assign is_vga = |vga_hit;

   assign take_susp = (state == ST_IDLE) && susp_pend;
   assign take_init = (state == ST_IDLE) && !susp_pend && init_pend;

   lcdseq_req #(.MODE_W(MODE_W)) i_req (
      .clk, .rst_n, .init_req, .init_lines, .suspend_req,
      .take_init, .take_susp, .init_pend, .susp_pend, .pend_lines
   );

   lcdseq_table #(.IDX_W(IDX_W)) i_table (
      .seq, .idx, .phase_dat, .res_dat, .step
   );

   lcdseq_msdelay #(
      .VDD_MS(VDD_MS), .GATE_MS(GATE_MS), .SETTLE_MS(SETTLE_MS), .SUSP_MS(SUSP_MS)
   ) i_delay (
      .clk, .rst_n,
      .active  (state == ST_RUN && step.kind == K_DLY),
      .sel     (step.dly),
      .ms_tick,
      .done    (dly_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         seq       <= S_UP;
         idx       <= '0;
         phase_dat <= 5'd0;
         res_dat   <= 5'd0;
         cv_level  <= '0;
         panel_on  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               idx <= '0;
               if (take_susp) begin
                  seq      <= S_DOWN;
                  cv_level <= '0;
                  state    <= ST_RUN;
               end else if (take_init) begin
                  seq       <= panel_on ? S_FAST : S_UP;
                  phase_dat <= !is_vga     ? {4'(PHASE_QVGA), 1'b1} :
                               phase_valid ? {phase_set, 1'b1} : 5'd1;
                  res_dat   <= is_vga ? 5'd0 : 5'd1;
                  cv_level  <= comv_valid ? comv_set : CV_W'(COMV_DEFAULT);
                  state     <= ST_RUN;
               end
            end
            default: begin
               unique case (step.kind)
                  K_WR:    if (wr_ready)  idx <= idx + IDX_W'(1);
                  K_CV:    if (comv_done) idx <= idx + IDX_W'(1);
                  K_DLY:   if (dly_done)  idx <= idx + IDX_W'(1);
                  default: begin
                     state    <= ST_IDLE;
                     panel_on <= (seq != S_DOWN);
                  end
               endcase
            end
         endcase
      end
   end

   assign busy       = (state == ST_RUN);
   assign wr_valid   = busy && step.kind == K_WR;
   assign wr_data    = step.word;
   assign comv_req   = busy && step.kind == K_CV;
   assign comv_level = cv_level;
   assign comv_base  = step.cv_base;

   assert_word_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));
   assert_cv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      comv_req && !comv_done |=> comv_req && $stable(comv_level) && $stable(comv_base));
   assert_cv_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && comv_req));
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_valid && !comv_req);
   assert_flag_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      panel_on != $past(panel_on) |-> !busy && $past(busy));

endmodule

// File: tb/test_lcd_pwr_seq.sv
module test_lcd_pwr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_req = 1'b0;
   logic [10:0] init_lines = '0;
   logic        suspend_req = 1'b0;
   logic        phase_valid = 1'b0;
   logic [3:0]  phase_set = '0;
   logic        comv_valid = 1'b0;
   logic [7:0]  comv_set = '0;
   logic        ms_tick = 1'b0;
   logic        wr_valid;
   logic        wr_ready = 1'b1;
   logic [7:0]  wr_data;
   logic        comv_req;
   logic        comv_done = 1'b0;
   logic [7:0]  comv_level;
   logic [4:0]  comv_base;
   logic        busy;
   logic        panel_on;

   always #2 clk = ~clk;   // 250 MHz

   lcd_pwr_seq i_lcd_pwr_seq (
      .clk, .rst_n, .init_req, .init_lines, .suspend_req, .phase_valid, .phase_set,
      .comv_valid, .comv_set, .ms_tick, .wr_valid, .wr_ready, .wr_data,
      .comv_req, .comv_done, .comv_level, .comv_base, .busy, .panel_on
   );

   // expected item: 0 word, 1 handoff, 2 wait, 3 end of series
   typedef struct packed {
      logic [1:0] k;
      logic [7:0] v;
      logic [4:0] b;
      logic [7:0] n;
      logic [3:0] tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   run_model = 0;
   bit   expect_next = 0;
   bit   hold_pend = 0;
   logic [7:0] hold_word = '0;
   bit   stall_en = 0;
   logic [7:0] lfsr = 8'h5B;
   bit   done_flag = 0;

   task automatic chk(input bit ok, input int tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic exp_t it_w(input logic [7:0] v, input int tag);
      it_w = '{k: 2'd0, v: v, b: 5'd0, n: 8'd0, tag: 4'(tag)};
   endfunction
   function automatic exp_t it_c(input logic [7:0] v, input logic [4:0] b);
      it_c = '{k: 2'd1, v: v, b: b, n: 8'd0, tag: 4'd4};
   endfunction
   function automatic exp_t it_d(input int n);
      it_d = '{k: 2'd2, v: 8'd0, b: 5'd0, n: 8'(n), tag: 4'd3};
   endfunction
   function automatic exp_t it_e(input bit on, input int tag);
      it_e = '{k: 2'd3, v: {7'd0, on}, b: 5'd0, n: 8'd0, tag: 4'(tag)};
   endfunction

   // R5: phase word, R6: resolution word, computed from the rules
   function automatic logic [7:0] ph_word(input int lines, input bit pv, input int ps);
      if (lines == 480 || lines == 640) ph_word = pv ? 8'(32 + (ps % 16) * 2 + 1) : 8'h21;
      else                              ph_word = 8'h33;
   endfunction
   function automatic logic [7:0] rs_word(input int lines);
      rs_word = (lines == 480 || lines == 640) ? 8'h00 : 8'h01;
   endfunction

   // R2 full power-up
   task automatic push_up(input int lines, input bit pv, input int ps, input bit cvv, input int cvs);
      q.push_back(it_w(8'hDF, 2)); q.push_back(it_w(8'h63, 2));
      q.push_back(it_w(8'h80, 2)); q.push_back(it_w(8'h84, 2));
      q.push_back(it_d(3));
      q.push_back(it_w(8'h67, 2)); q.push_back(it_w(8'hC9, 2));
      q.push_back(it_c(cvv ? 8'(cvs) : 8'd125, 5'h04));
      q.push_back(it_w(8'h77, 2)); q.push_back(it_w(8'h86, 2));
      q.push_back(it_d(2));
      q.push_back(it_w(8'hC1, 2)); q.push_back(it_w(8'h7F, 2));
      q.push_back(it_w(8'h87, 2)); q.push_back(it_w(8'hC0, 2));
      q.push_back(it_w(ph_word(lines, pv, ps), 5));
      q.push_back(it_w(8'hE0, 2));
      q.push_back(it_d(1));
      q.push_back(it_w(rs_word(lines), 6));
      q.push_back(it_e(1'b1, 2));
   endtask

   // R7 short path
   task automatic push_fast(input int lines, input bit pv, input int ps);
      q.push_back(it_w(ph_word(lines, pv, ps), 7));
      q.push_back(it_w(rs_word(lines), 7));
      q.push_back(it_e(1'b1, 7));
   endtask

   // R8 shutdown
   task automatic push_down();
      q.push_back(it_d(34));
      q.push_back(it_w(8'h86, 8)); q.push_back(it_w(8'hC8, 8));
      q.push_back(it_w(8'h74, 8));
      q.push_back(it_c(8'd0, 5'h14));
      q.push_back(it_w(8'h84, 8)); q.push_back(it_w(8'h64, 8));
      q.push_back(it_w(8'hDE, 8)); q.push_back(it_w(8'h60, 8));
      q.push_back(it_w(8'h80, 8));
      q.push_back(it_e(1'b0, 8));
   endtask

   // stimulus drivers: change 1 ns after a rising edge
   initial forever begin
      @(posedge clk); #1;
      ms_tick = 1'b0;
      if (($time / 4) % 20 == 0) ms_tick = 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_ready = stall_en ? lfsr[0] : 1'b1;
   end

   // DAC-write responder: done three cycles into a request
   initial begin
      int c = 0;
      forever begin
         @(posedge clk); #1;
         comv_done = 1'b0;
         if (comv_req) begin
            c++;
            if (c == 3) begin comv_done = 1'b1; c = 0; end
         end else c = 0;
      end
   end

   // reference model, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n && run_model) begin
         exp_t it;
         if (hold_pend) chk(wr_valid && wr_data == hold_word, 1, "word held under back-pressure", wr_data, hold_word); // R1
         hold_pend = wr_valid && !wr_ready;
         hold_word = wr_data;
         if (q.size() == 0) begin
            if (wr_valid || comv_req) chk(1'b0, 10, "activity with nothing due", wr_data, 0); // R10
         end else begin
            it = q[0];
            case (it.k)
               2'd2: begin // R3
                  if (wr_valid || comv_req) chk(1'b0, 3, "activity during wait", wr_data, 0);
                  if (busy && ms_tick) begin
                     it.n = it.n - 8'd1;
                     if (it.n == 8'd0) begin void'(q.pop_front()); expect_next = 1; end
                     else q[0] = it;
                  end
               end
               2'd0: begin
                  if (expect_next) chk(wr_valid, 3, "word right after wait", wr_valid, 1);
                  expect_next = 0;
                  if (comv_req) chk(1'b0, 4, "handoff instead of word", comv_level, it.v);
                  if (wr_valid) begin
                     chk(wr_data == it.v, int'(it.tag), "word", wr_data, it.v);
                     if (wr_ready) void'(q.pop_front());
                  end
               end
               2'd1: begin // R4
                  if (expect_next) chk(comv_req, 3, "handoff right after wait", comv_req, 1);
                  expect_next = 0;
                  if (wr_valid) chk(1'b0, 4, "word during handoff", wr_data, 0);
                  if (comv_req) begin
                     chk(comv_level == it.v, 4, "handoff level", comv_level, it.v);
                     chk(comv_base == it.b, 4, "handoff base", comv_base, it.b);
                     if (comv_done) void'(q.pop_front());
                  end
               end
               default: begin
                  if (wr_valid || comv_req) chk(1'b0, int'(it.tag), "extra activity at series end", wr_data, 0);
                  if (!busy) begin
                     chk(panel_on == it.v[0], int'(it.tag), "panel_on after series", panel_on, it.v[0]);
                     void'(q.pop_front());
                  end
               end
            endcase
         end
      end
   end

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic pulse_init(input int lines);
      @(posedge clk); #1; init_req = 1'b1; init_lines = 11'(lines);
      @(posedge clk); #1; init_req = 1'b0;
   endtask

   task automatic pulse_susp();
      @(posedge clk); #1; suspend_req = 1'b1;
      @(posedge clk); #1; suspend_req = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(posedge clk);
      repeat (3) @(posedge clk);
      chk(!busy, 10, "busy low after all series", busy, 0); // R10
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, 10, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!busy, 10, "busy after reset", busy, 0);
      chk(!wr_valid, 10, "wr_valid after reset", wr_valid, 0);
      chk(!comv_req, 10, "comv_req after reset", comv_req, 0);
      chk(!panel_on, 10, "panel_on after reset", panel_on, 0);
      run_model = 1;

      // R2 R5 R6: full power-up, 640 lines, phase setting 5, default level 125
      phase_valid = 1'b1; phase_set = 4'd5; comv_valid = 1'b0;
      push_up(640, 1, 5, 0, 0);
      pulse_init(640);
      drain();

      // R7: already on, 240 lines -> short path
      push_fast(240, 1, 5);
      pulse_init(240);
      drain();

      // R5 R7: 480 lines, no phase setting
      phase_valid = 1'b0;
      push_fast(480, 0, 0);
      pulse_init(480);
      drain();

      // R8 shutdown
      push_down();
      pulse_susp();
      drain();

      // R1 R4: power-up under back-pressure with a configured level
      stall_en = 1; comv_valid = 1'b1; comv_set = 8'h5A;
      push_up(320, 0, 0, 1, 8'h5A);
      pulse_init(320);
      drain();
      stall_en = 0;

      // R9: init(640), init(480) and suspend all arrive during a suspend;
      // suspend runs first, then init with the last line count
      phase_valid = 1'b1; phase_set = 4'd7;
      push_down();
      push_down();
      push_up(480, 1, 7, 1, 8'h5A);
      pulse_susp();
      repeat (10) @(posedge clk);
      chk(busy, 9, "busy during shutdown", busy, 1);
      pulse_init(640);
      pulse_init(480);
      pulse_susp();
      drain();

      // R6 R7: other line count takes the reduced-resolution word
      push_fast(600, 1, 7);
      pulse_init(600);
      drain();

      finish_up();
   end

endmodule